// File: doc/BRIEF.md
# Single-Pin GPIO Controller with Interrupt Detection

This block controls one general-purpose I/O pad through four registers on a simple synchronous read/write bus. A control register selects the pin function and the output enable. It also stores bias and drive settings, which go out unchanged to the pad cell. An I/O register carries the output level and shows the synchronized pad input. The pad input goes through a two-flop synchronizer before it is read or tested for events.

An interrupt configuration register chooses what the detector looks for. A 2-bit mode field picks level, rising edge, falling edge or both edges. A polarity bit picks the active level in level mode, and it must be set for any edge mode to fire. A raw-status enable bit lets the status latch at all. A 3-bit target field is stored and exported for routing. The status bit is sticky, and software clears it by writing zero. The interrupt request is the status gated by an enable bit.

Top module: `gpio_irq_pin`

## Requirements
- R1: After a synchronous active-high reset, all four registers read as zero, and pad_oe, pad_out, func_sel, bias_sel, drive_sel, irq_target and irq are all zero.
- R2: Control register (address 0): bit 0 output enable, bits [3:1] function select (0 = plain GPIO, other values passed out as they are), bits [5:4] bias (0 none, 1 pull-down, 2 keeper, 3 pull-up), bits [8:6] drive code (code n means (n+1)*2 mA). The fields read back as written and appear on func_sel, bias_sel and drive_sel.
- R3: pad_oe follows control bit 0 from the cycle after the write. pad_out follows I/O register bit 0 (address 1).
- R4: I/O register bit 1 is read-only and shows the pad input after two synchronizer flops. A pad change is first visible in a read issued two cycles after the change. Writing bit 1 has no effect.
- R5: Interrupt configuration (address 2): bit 0 enable, bits [2:1] mode, bit 3 polarity, bit 4 raw-status enable, bits [7:5] target. Mode 1 with polarity 1 sets the status on a low-to-high input transition only.
- R6: Mode 2 with polarity 1 sets the status on a high-to-low transition only.
- R7: Mode 3 with polarity 1 sets the status on either transition.
- R8: In modes 1 to 3 with polarity 0, the status never sets.
- R9: In mode 0, polarity 1 sets the status while the input is high and polarity 0 sets it while the input is low. Clearing the status while the level still holds sets it again on the next cycle.
- R10: Status (address 3, bit 0) is sticky. Writing 0 clears it. Writing 1 has no effect. When a set and a clear fall in the same cycle, the set wins.
- R11: While the raw-status enable is 0, no condition sets the status.
- R12: irq is high exactly when the status and the interrupt enable are both set. irq_target outputs the target field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| pad_in | input | 1 | Asynchronous pad input |
| pad_out | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad output enable |
| func_sel | output | 3 | Selected pin function |
| bias_sel | output | 2 | Stored bias setting |
| drive_sel | output | 3 | Stored drive-strength code |
| irq_target | output | 3 | Stored interrupt routing target |
| irq | output | 1 | Interrupt request |

## Verification
Each of the eight mode and polarity combinations is driven with the same pad sequence: held low, raised, cleared while high, then lowered. The four status samples from that sequence tell the combinations apart. Rising, falling and both-edge modes differ in which transitions latch. Level modes differ from edge modes because the status sets again after a clear while the level still holds. Edge modes with polarity 0 stay silent throughout. Directed cases then check that a clear landing in the same cycle as a detected edge loses to the set, that the raw-status enable blocks latching, and that the synchronizer delay is exactly two cycles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int FUNC_W = 3;
  localparam int BIAS_W = 2;
  localparam int DRV_W  = 3;
  localparam int MODE_W = 2;
  localparam int TGT_W  = 3;

  localparam int A_CTRL = 0;
  localparam int A_IO   = 1;
  localparam int A_ICFG = 2;
  localparam int A_STAT = 3;

  localparam int OUT_BIT = 0;
  localparam int IN_BIT  = 1;
  localparam int STS_BIT = 0;

  typedef enum logic [MODE_W-1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;

  // Packed LSB-last: oe at bit 0, then function, bias, drive.
  typedef struct packed {
    logic [DRV_W-1:0]  drive;
    logic [BIAS_W-1:0] bias;
    logic [FUNC_W-1:0] func;
    logic              oe;
  } ctrl_t;

  // Packed LSB-last: enable at bit 0, mode, polarity, raw enable, target.
  typedef struct packed {
    logic [TGT_W-1:0] target;
    logic             raw_en;
    logic             pol;
    det_mode_e        mode;
    logic             en;
  } icfg_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int ICFG_W = $bits(icfg_t);

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pad,
  output logic level,
  output logic prev
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= pad;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[LAST];
  end

  assign level = chain_q[LAST];
  assign prev  = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      level,
  input  logic      prev,
  input  det_mode_e mode,
  input  logic      pol,
  input  logic      raw_en,
  input  logic      clr,
  output logic      sts
);
  logic rise, fall, hit, sts_q;

  assign rise = level & ~prev;
  assign fall = ~level & prev;

  always_comb begin
    unique case (mode)
      DET_LEVEL: hit = pol ? level : ~level;
      DET_RISE:  hit = pol & rise;
      DET_FALL:  hit = pol & fall;
      DET_BOTH:  hit = pol & (rise | fall);
      default:   hit = 1'b0;
    endcase
  end

  // A hardware set has priority over a software clear.
  always_ff @(posedge clk) begin
    if (rst)                sts_q <= 1'b0;
    else if (raw_en && hit) sts_q <= 1'b1;
    else if (clr)           sts_q <= 1'b0;
  end

  assign sts = sts_q;
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              in_level,
  input  logic              sts,
  output ctrl_t             ctrl,
  output logic              out_bit,
  output icfg_t             icfg,
  output logic              sts_clr
);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_IO   = ADDR_W'(A_IO);
  localparam logic [ADDR_W-1:0] AD_ICFG = ADDR_W'(A_ICFG);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);

  ctrl_t             ctrl_q;
  icfg_t             icfg_q;
  logic              out_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      icfg_q <= '0;
      out_q  <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        AD_CTRL: ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        AD_IO:   out_q  <= bus_wdata[OUT_BIT];
        AD_ICFG: icfg_q <= icfg_t'(bus_wdata[ICFG_W-1:0]);
        default: ;
      endcase
    end
  end

  assign sts_clr = bus_wr && (bus_addr == AD_STAT) && !bus_wdata[STS_BIT];

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AD_CTRL: rd_mux[CTRL_W-1:0] = ctrl_q;
      AD_IO: begin
        rd_mux[OUT_BIT] = out_q;
        rd_mux[IN_BIT]  = in_level;
      end
      AD_ICFG: rd_mux[ICFG_W-1:0] = icfg_q;
      AD_STAT: rd_mux[STS_BIT]    = sts;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign ctrl      = ctrl_q;
  assign icfg      = icfg_q;
  assign out_bit   = out_q;
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  output logic [2:0]        func_sel,
  output logic [1:0]        bias_sel,
  output logic [2:0]        drive_sel,
  output logic [2:0]        irq_target,
  output logic              irq
);
  logic      sync_level, sync_prev;
  logic      sts_q, sts_clr, out_bit;
  ctrl_t     ctrl;
  icfg_t     icfg;
  det_mode_e cfg_mode;
  logic      cfg_pol, cfg_raw, cfg_en;

  gpio_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pad   (pad_in),
    .level (sync_level),
    .prev  (sync_prev)
  );

  gpio_reg_file #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .in_level  (sync_level),
    .sts       (sts_q),
    .ctrl      (ctrl),
    .out_bit   (out_bit),
    .icfg      (icfg),
    .sts_clr   (sts_clr)
  );

  assign cfg_mode = icfg.mode;
  assign cfg_pol  = icfg.pol;
  assign cfg_raw  = icfg.raw_en;
  assign cfg_en   = icfg.en;

  gpio_irq_detect u_det (
    .clk    (clk),
    .rst    (rst),
    .level  (sync_level),
    .prev   (sync_prev),
    .mode   (cfg_mode),
    .pol    (cfg_pol),
    .raw_en (cfg_raw),
    .clr    (sts_clr),
    .sts    (sts_q)
  );

  assign pad_out    = out_bit;
  assign pad_oe     = ctrl.oe;
  assign func_sel   = ctrl.func;
  assign bias_sel   = ctrl.bias;
  assign drive_sel  = ctrl.drive;
  assign irq_target = icfg.target;
  assign irq        = sts_q & cfg_en;
endmodule

// File: rtl/gpio_irq_pin_chk.sv
module gpio_irq_pin_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              pad_in,
  input logic              pad_oe,
  input logic              irq,
  input logic              sync_level,
  input logic              sts,
  input logic [1:0]        mode,
  input logic              pol,
  input logic              raw_en,
  input logic              en
);
  logic [1:0] since_rst;
  logic       clr_wr;

  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign clr_wr = bus_wr && (bus_addr == ADDR_W'(3)) && !bus_wdata[0];

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (sync_level == $past(pad_in, 2)));

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sts && !clr_wr) |=> sts);

  // R11
  raw_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!raw_en && !sts) |=> !sts);

  // R8
  edge_nopol_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode != 2'd0) && !pol && !sts) |=> !sts);

  // R9
  level_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (raw_en && (mode == 2'd0) && pol && sync_level) |=> sts);

  // R3
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == ADDR_W'(0))) |=> (pad_oe == $past(bus_wdata[0])));

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !irq);
endmodule

bind gpio_irq_pin gpio_irq_pin_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .pad_in     (pad_in),
  .pad_oe     (pad_oe),
  .irq        (irq),
  .sync_level (sync_level),
  .sts        (sts_q),
  .mode       (cfg_mode),
  .pol        (cfg_pol),
  .raw_en     (cfg_raw),
  .en         (cfg_en)
);

// File: tb/gpio_irq_pin_bench.sv
module gpio_irq_pin_bench;
  localparam int DW = 32;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          pad_in = 1'b0;
  logic          pad_out, pad_oe, irq;
  logic [2:0]    func_sel, drive_sel, irq_target;
  logic [1:0]    bias_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] rd;

  // {mode[1:0], pol, s_low, s_high, s_after_clear, s_low_again}
  localparam logic [6:0] VEC [8] = '{
    7'b00_0_1101, 7'b00_1_0111, 7'b01_1_0100, 7'b10_1_0001,
    7'b11_1_0101, 7'b01_0_0000, 7'b10_0_0000, 7'b11_0_0000
  };

  gpio_irq_pin u_gpio_irq_pin (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .func_sel(func_sel), .bias_sel(bias_sel), .drive_sel(drive_sel),
    .irq_target(irq_target), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdreg(input int a);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    rd = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] icfg(input logic en, input logic [1:0] m,
                                         input logic p, input logic raw, input logic [2:0] t);
    return DW'({t, raw, p, m, en});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string tag;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rdreg(a); check("R1 reg", rd, 0); end
    check("R1 outs", {pad_oe, pad_out, func_sel, bias_sel, drive_sel, irq_target, irq}, 0);

    // R2/R3 control fields
    wr(0, 32'h1AB); idle(1);
    check("R2 func", func_sel, 5);
    check("R2 bias", bias_sel, 2);
    check("R2 drive", drive_sel, 6);
    check("R3 oe", pad_oe, 1);
    rdreg(0); check("R2 readback", rd, 32'h1AB);
    wr(1, 32'h3); idle(1);
    check("R3 out", pad_out, 1);
    rdreg(1); check("R4 input bit not writable", rd, 32'h1);
    wr(0, 32'h0); idle(1);
    check("R3 oe off", pad_oe, 0);

    // R4 synchronizer latency
    pad_in = 1'b1;
    rdreg(1); check("R4 stage1", rd[1], 0);
    rdreg(1); check("R4 stage2", rd[1], 0);
    rdreg(1); check("R4 visible", rd[1], 1);
    pad_in = 1'b0; idle(4);

    // Vector table over every mode and polarity
    for (int v = 0; v < 8; v++) begin
      logic [6:0] e;
      e = VEC[v];
      if (!e[4] && e[6:5] != 2'd0) tag = "R8";
      else case (e[6:5])
        2'd0: tag = "R9";
        2'd1: tag = "R5";
        2'd2: tag = "R6";
        default: tag = "R7";
      endcase
      pad_in = 1'b0; idle(4);
      wr(2, icfg(1'b1, e[6:5], e[4], 1'b1, 3'd4));
      wr(3, 0); idle(2);
      rdreg(3); check({tag, " low"}, rd[0], e[3]);
      check("R12 irq", irq, e[3]);
      pad_in = 1'b1; idle(4);
      rdreg(3); check({tag, " high"}, rd[0], e[2]);
      wr(3, 0); idle(2);
      rdreg(3); check({tag, " cleared high"}, rd[0], e[1]);
      pad_in = 1'b0; idle(4);
      rdreg(3); check({tag, " low again"}, rd[0], e[0]);
    end

    // R10 write semantics and set-over-clear priority
    wr(2, icfg(1'b1, 2'd1, 1'b1, 1'b1, 3'd0));
    wr(3, 0);
    pad_in = 1'b1; idle(4);
    wr(3, 1); idle(1);
    rdreg(3); check("R10 write one keeps", rd[0], 1);
    wr(3, 0); idle(1);
    rdreg(3); check("R10 clear", rd[0], 0);
    pad_in = 1'b0; idle(4);
    wr(3, 0);
    pad_in = 1'b1;
    idle(2);
    wr(3, 0); idle(1);
    rdreg(3); check("R10 set wins", rd[0], 1);

    // R11 raw enable off
    pad_in = 1'b0; idle(4);
    wr(2, icfg(1'b1, 2'd1, 1'b1, 1'b0, 3'd0));
    wr(3, 0);
    pad_in = 1'b1; idle(4);
    rdreg(3); check("R11 no latch", rd[0], 0);
    check("R11 irq", irq, 0);

    // R12 enable gating and target export
    wr(2, icfg(1'b0, 2'd0, 1'b1, 1'b1, 3'd6)); idle(2);
    rdreg(3); check("R12 status set", rd[0], 1);
    check("R12 irq gated", irq, 0);
    check("R12 target", irq_target, 6);
    rdreg(2); check("R5 cfg readback", rd, 32'hD8);
    wr(2, icfg(1'b1, 2'd0, 1'b1, 1'b1, 3'd6)); idle(1);
    check("R12 irq on", irq, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule